// File: doc/BRIEF.md
# Legacy Low-Memory Shadow Attribute Decoder

This block keeps the control bytes that decide how the legacy area below 1 MB is split between system RAM and the PCI bus. Seven shadow-control bytes set the read and write target of thirteen regions. Region 0 is the 64 KB firmware area at 0xF0000. Regions 1 to 12 are 16 KB expansion blocks that start at 0xC0000. One more byte controls the 128 KB graphics window at 0xA0000.

Software writes these bytes one at a time through a byte-wide configuration port, and a readback port returns them. The block decodes the bytes into a 2-bit attribute for each region and into two visibility controls for the graphics window. It also offers a combinational lookup: given a 20-bit address, it returns the matching region and whether reads and writes at that address go to RAM.

Top module: `shadow_attr_decoder`

## Requirements
- R1: Synchronous active-high reset clears the seven shadow bytes (offsets 0x59..0x5F) to 0x00 and sets the window byte (offset 0x72) to 0x02. After reset, every region attribute is 00, the window is routed to PCI for normal accesses, and the SMM RAM view is off.
- R2: A write with `wr_en` high to offset 0x59..0x5F or 0x72 stores the full data byte. `rd_data` returns the stored byte for those offsets and 0x00 for any other `rd_addr`.
- R3: A write to any other offset changes no stored byte and no output.
- R4: Region r takes its attribute from the byte at offset 0x59 + floor((r+1)/2). An even r uses bits [1:0] of that byte and an odd r uses bits [5:4]. Field r of `region_attr` sits at bits [2r+1:2r].
- R5: In each 2-bit attribute, bit 0 set sends reads to RAM and bit 1 set sends writes to RAM, so 00 = PCI for both, 01 = read RAM / write PCI, 10 = read PCI / write RAM, and 11 = RAM for both.
- R6: `legacy_pci_view` is high exactly when bit 6 (open) of the window byte is clear.
- R7: `smm_ram_view` equals bit 3 (global enable) of the window byte.
- R8: A stored write shows on `region_attr`, `legacy_pci_view`, `smm_ram_view` and the lookup from the first clock edge that takes it, with no further delay.
- R9: For `lk_addr` in 0xF0000..0xFFFFF, `lk_hit` is 1 and `lk_region` is 0. For `lk_addr` in 0xC0000..0xEFFFF, `lk_hit` is 1 and `lk_region` is 1 + (lk_addr - 0xC0000)/0x4000. On a hit, `lk_rd_ram` and `lk_wr_ram` are bits 0 and 1 of that region's attribute.
- R10: For `lk_addr` below 0xC0000, `lk_hit`, `lk_region`, `lk_rd_ram` and `lk_wr_ram` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration byte write strobe |
| wr_addr | input | 8 | Configuration offset written |
| wr_data | input | 8 | Byte written |
| rd_addr | input | 8 | Configuration offset read back |
| rd_data | output | 8 | Stored byte at rd_addr, 0 if unmapped |
| region_attr | output | 26 | Thirteen 2-bit region attributes, region r at [2r+1:2r] |
| legacy_pci_view | output | 1 | Graphics window routed to PCI for normal accesses |
| smm_ram_view | output | 1 | RAM view of the window enabled for SMM accesses |
| lk_addr | input | 20 | Address for the region lookup |
| lk_hit | output | 1 | Address falls in a shadow region |
| lk_region | output | 4 | Index of the matching region |
| lk_rd_ram | output | 1 | Reads at lk_addr go to RAM |
| lk_wr_ram | output | 1 | Writes at lk_addr go to RAM |

## Verification
A byte stored in the wrong slot, or a nibble picked from the wrong half, shows up at once in two regions' fields of `region_attr` and in the lookup results for both. The reference model compares against its own copy of the configuration space on every cycle, so an error is caught in the first cycle after the offending write. Expansion block boundaries are probed at their first and last byte, so an off-by-one in the region index shows up as the wrong region number or the wrong RAM steering. Writes to neighbouring offsets are followed by full readback and output comparison, so a write that leaks into a stored byte is detected on the next cycle.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam int NUM_REGIONS = 13;
    localparam int PAM_BYTES   = 7;
    localparam int ATTR_W      = 2;
    localparam int REG_IDX_W   = $clog2(NUM_REGIONS);
    localparam int LK_ADDR_W   = 20;

    localparam logic [7:0] PAM_BASE_OFS = 8'h59;
    localparam logic [7:0] WIN_CTL_OFS  = 8'h72;
    localparam logic [7:0] WIN_CTL_RST  = 8'h02;
    localparam int         WIN_OPEN_BIT = 6;
    localparam int         WIN_GEN_BIT  = 3;

    localparam logic [LK_ADDR_W-1:0] FW_BASE  = 20'hF0000;
    localparam logic [LK_ADDR_W-1:0] EXP_BASE = 20'hC0000;
    localparam int                   EXP_SHIFT = 14;

    // bit 1 steers writes, bit 0 steers reads
    typedef struct packed {
        logic wr_ram;
        logic rd_ram;
    } attr_t;

    typedef struct packed {
        logic                 hit;
        logic [REG_IDX_W-1:0] region;
        attr_t                attr;
    } lookup_t;

    function automatic int ctl_byte_of(input int region);
        return (region + 1) / 2;
    endfunction

    function automatic int nibble_lsb_of(input int region);
        return (region % 2 == 1) ? 4 : 0;
    endfunction

endpackage

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import shadow_pkg::*;
#(
    parameter int N_PAM = PAM_BYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_addr,
    output logic [7:0]         rd_data,
    output logic [N_PAM*8-1:0] pam_q,
    output logic [7:0]         win_q
);

    logic [7:0] pam_r [N_PAM];
    logic [7:0] win_r;
    logic       known_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_PAM; i++) pam_r[i] <= 8'h00;
            win_r <= WIN_CTL_RST;
        end else if (wr_en) begin
            for (int i = 0; i < N_PAM; i++) begin
                if (wr_addr == PAM_BASE_OFS + 8'(i)) pam_r[i] <= wr_data;
            end
            if (wr_addr == WIN_CTL_OFS) win_r <= wr_data;
        end
    end

    always_comb begin
        known_wr = (wr_addr == WIN_CTL_OFS);
        for (int i = 0; i < N_PAM; i++) begin
            if (wr_addr == PAM_BASE_OFS + 8'(i)) known_wr = 1'b1;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == WIN_CTL_OFS) rd_data = win_r;
        for (int i = 0; i < N_PAM; i++) begin
            if (rd_addr == PAM_BASE_OFS + 8'(i)) rd_data = pam_r[i];
        end
    end

    for (genvar g = 0; g < N_PAM; g++) begin : g_flat
        assign pam_q[g*8 +: 8] = pam_r[g];
    end
    assign win_q = win_r;

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (win_q == WIN_CTL_RST) && (pam_q == '0));

    // R2
    win_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == WIN_CTL_OFS) |=> win_q == $past(wr_data));

    // R3
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !known_wr) |=> $stable(pam_q) && $stable(win_q));

endmodule

// File: rtl/shadow_region_map.sv
module shadow_region_map
    import shadow_pkg::*;
#(
    parameter int N_PAM = PAM_BYTES,
    parameter int N_REG = NUM_REGIONS
) (
    input  logic [N_PAM*8-1:0]      pam_q,
    output logic [N_REG*ATTR_W-1:0] region_attr
);

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        localparam int BYTE_IX = ctl_byte_of(r);
        localparam int LSB     = BYTE_IX * 8 + nibble_lsb_of(r);
        assign region_attr[r*ATTR_W +: ATTR_W] = pam_q[LSB +: ATTR_W];
    end

endmodule

// File: rtl/shadow_addr_lookup.sv
module shadow_addr_lookup
    import shadow_pkg::*;
#(
    parameter int N_REG  = NUM_REGIONS,
    parameter int ADDR_W = LK_ADDR_W
) (
    input  logic [ADDR_W-1:0]       lk_addr,
    input  logic [N_REG*ATTR_W-1:0] region_attr,
    output lookup_t                 result
);

    logic [ADDR_W-1:0]    offset;
    logic [REG_IDX_W-1:0] idx;

    always_comb begin
        offset = lk_addr - EXP_BASE;
        idx    = '0;
        result = '0;
        if (lk_addr >= FW_BASE) begin
            result.hit = 1'b1;
            idx        = '0;
        end else if (lk_addr >= EXP_BASE) begin
            result.hit = 1'b1;
            idx        = REG_IDX_W'(offset >> EXP_SHIFT) + REG_IDX_W'(1);
        end
        if (result.hit) begin
            result.region = idx;
            for (int r = 0; r < N_REG; r++) begin
                if (idx == REG_IDX_W'(r)) result.attr = attr_t'(region_attr[r*ATTR_W +: ATTR_W]);
            end
        end
    end

endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
    import shadow_pkg::*;
#(
    parameter int N_PAM  = PAM_BYTES,
    parameter int N_REG  = NUM_REGIONS,
    parameter int ADDR_W = LK_ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [7:0]              wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [7:0]              rd_addr,
    output logic [7:0]              rd_data,
    output logic [N_REG*ATTR_W-1:0] region_attr,
    output logic                    legacy_pci_view,
    output logic                    smm_ram_view,
    input  logic [ADDR_W-1:0]       lk_addr,
    output logic                    lk_hit,
    output logic [REG_IDX_W-1:0]    lk_region,
    output logic                    lk_rd_ram,
    output logic                    lk_wr_ram
);

    logic [N_PAM*8-1:0] pam_q;
    logic [7:0]         win_q;
    lookup_t            lk_res;

    shadow_regfile #(.N_PAM(N_PAM)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pam_q   (pam_q),
        .win_q   (win_q)
    );

    shadow_region_map #(.N_PAM(N_PAM), .N_REG(N_REG)) u_map (
        .pam_q       (pam_q),
        .region_attr (region_attr)
    );

    shadow_addr_lookup #(.N_REG(N_REG), .ADDR_W(ADDR_W)) u_lookup (
        .lk_addr     (lk_addr),
        .region_attr (region_attr),
        .result      (lk_res)
    );

    assign legacy_pci_view = ~win_q[WIN_OPEN_BIT];
    assign smm_ram_view    = win_q[WIN_GEN_BIT];
    assign lk_hit          = lk_res.hit;
    assign lk_region       = lk_res.region;
    assign lk_rd_ram       = lk_res.attr.rd_ram;
    assign lk_wr_ram       = lk_res.attr.wr_ram;

    // R6
    pci_view_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == WIN_CTL_OFS) |=> legacy_pci_view == !$past(wr_data[WIN_OPEN_BIT]));

    // R7
    smm_view_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == WIN_CTL_OFS) |=> smm_ram_view == $past(wr_data[WIN_GEN_BIT]));

    // R9
    fw_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_addr >= FW_BASE) |-> (lk_hit && lk_region == '0
                                  && lk_rd_ram == region_attr[0] && lk_wr_ram == region_attr[1]));

    // R10
    low_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_addr < EXP_BASE) |-> !(lk_hit || lk_rd_ram || lk_wr_ram) && lk_region == '0);

    // R9
    region_range_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_region < REG_IDX_W'(N_REG));

endmodule

// File: tb/tb_shadow_attr_decoder.sv
module tb_shadow_attr_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_addr = 8'h00;
    logic [7:0]  rd_data;
    logic [25:0] region_attr;
    logic        legacy_pci_view;
    logic        smm_ram_view;
    logic [19:0] lk_addr = 20'h00000;
    logic        lk_hit;
    logic [3:0]  lk_region;
    logic        lk_rd_ram;
    logic        lk_wr_ram;

    int total = 0;
    int bad   = 0;
    bit live_chk = 1'b0;
    bit finished = 1'b0;

    logic [7:0] cfg [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_attr_decoder dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .region_attr(region_attr),
        .legacy_pci_view(legacy_pci_view), .smm_ram_view(smm_ram_view),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_region(lk_region),
        .lk_rd_ram(lk_rd_ram), .lk_wr_ram(lk_wr_ram)
    );

    function automatic bit is_cfg(input logic [7:0] a);
        return (a >= 8'h59 && a <= 8'h5F) || a == 8'h72;
    endfunction

    // behavioural configuration-space model
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) cfg[i] = 8'h00;
            cfg[8'h72] = 8'h02;
        end else if (wr_en && is_cfg(wr_addr)) begin
            cfg[wr_addr] = wr_data;
        end
    end

    function automatic logic [1:0] model_attr(input int r);
        logic [7:0] b;
        b = cfg[8'h59 + (r + 1) / 2];
        return (r % 2 == 1) ? b[5:4] : b[1:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live_chk && !rst) begin
            logic [25:0] ea;
            logic [7:0]  erd;
            int          reg_ix;
            bit          ehit;
            for (int r = 0; r < 13; r++) ea[r*2 +: 2] = model_attr(r);
            check("R4 R5 R8 region_attr", 32'(region_attr), 32'(ea));
            check("R6 legacy_pci_view", 32'(legacy_pci_view), 32'(!cfg[8'h72][6]));
            check("R7 smm_ram_view", 32'(smm_ram_view), 32'(cfg[8'h72][3]));
            erd = is_cfg(rd_addr) ? cfg[rd_addr] : 8'h00;
            check("R2 R3 rd_data", 32'(rd_data), 32'(erd));
            ehit = 1'b0;
            reg_ix = 0;
            if (lk_addr >= 20'hF0000) begin
                ehit = 1'b1;
                reg_ix = 0;
            end else if (lk_addr >= 20'hC0000) begin
                ehit = 1'b1;
                reg_ix = 1 + int'((lk_addr - 20'hC0000) / 20'h4000);
            end
            if (ehit) begin
                logic [1:0] a;
                a = model_attr(reg_ix);
                check("R9 lookup", {25'b0, lk_hit, lk_region, lk_rd_ram, lk_wr_ram},
                      {25'b0, 1'b1, 4'(reg_ix), a[0], a[1]});
            end else begin
                check("R10 lookup miss", {25'b0, lk_hit, lk_region, lk_rd_ram, lk_wr_ram}, 32'h0);
            end
        end
    end

    task automatic step(input bit we, input logic [7:0] wa, input logic [7:0] wd,
                        input logic [7:0] ra, input logic [19:0] la);
        @(negedge clk);
        #2;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; lk_addr = la;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2 rst = 1'b0;
        rd_addr = 8'h72;
        @(negedge clk);
        // R1 reset state
        check("R1 region_attr", 32'(region_attr), 32'h0);
        check("R1 legacy_pci_view", 32'(legacy_pci_view), 32'h1);
        check("R1 smm_ram_view", 32'(smm_ram_view), 32'h0);
        check("R1 window byte", 32'(rd_data), 32'h02);
        live_chk = 1'b1;

        // R4 distinct nibble patterns per byte
        for (int i = 0; i < 7; i++) step(1'b1, 8'h59 + 8'(i), 8'h31 + 8'(i * 16), 8'h59 + 8'(i), 20'hF0000);
        step(1'b0, 8'h00, 8'h00, 8'h5C, 20'hC0000);
        // R9 boundary sweep
        for (int k = 0; k < 12; k++) begin
            step(1'b0, 8'h00, 8'h00, 8'h5A, 20'hC0000 + 20'(k) * 20'h4000);
            step(1'b0, 8'h00, 8'h00, 8'h5B, 20'hC0000 + 20'(k) * 20'h4000 + 20'h3FFF);
        end
        step(1'b0, 8'h00, 8'h00, 8'h59, 20'hFFFFF);
        // R10 misses
        step(1'b0, 8'h00, 8'h00, 8'h59, 20'hBFFFF);
        step(1'b0, 8'h00, 8'h00, 8'h59, 20'hA0000);
        step(1'b0, 8'h00, 8'h00, 8'h59, 20'h00000);
        // R5 all four encodings in region 1 and 2
        for (int e = 0; e < 4; e++) begin
            step(1'b1, 8'h5A, 8'(e) | 8'(e << 4), 8'h5A, 20'hC0000);
            step(1'b0, 8'h00, 8'h00, 8'h5A, 20'hC4000);
        end
        // R6 R7 window control
        step(1'b1, 8'h72, 8'h40, 8'h72, 20'hA0000);
        step(1'b1, 8'h72, 8'h08, 8'h72, 20'hA0000);
        step(1'b1, 8'h72, 8'h48, 8'h72, 20'hA0000);
        step(1'b1, 8'h72, 8'hB7, 8'h72, 20'hA0000);
        // R3 stray offsets
        step(1'b1, 8'h58, 8'hFF, 8'h58, 20'hF8000);
        step(1'b1, 8'h60, 8'hFF, 8'h60, 20'hEC000);
        step(1'b1, 8'h71, 8'hFF, 8'h5F, 20'hE8000);
        step(1'b1, 8'h73, 8'hFF, 8'h72, 20'hC8000);
        step(1'b0, 8'h00, 8'h00, 8'h59, 20'hF0000);
        // R2 R8 random traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0]  a;
            logic [19:0] l;
            a = 8'h56 + 8'($urandom_range(0, 30));
            if (a > 8'h62) a = 8'h72 + 8'($urandom_range(0, 2)) - 8'h01;
            l = ($urandom_range(0, 3) == 0) ? 20'($urandom) : 20'hC0000 + 20'($urandom_range(0, 20'h3FFFF));
            step(1'($urandom_range(0, 1)), a, 8'($urandom), 8'h57 + 8'($urandom_range(0, 28)), l);
        end
        step(1'b0, 8'h00, 8'h00, 8'h72, 20'h00000);
        @(negedge clk);
        live_chk = 1'b0;
        finish_run();
    end

endmodule